// File: doc/BRIEF.md
# PCI configuration address translator

This block sits in a host-to-PCI bridge between the CPU and the unit that runs configuration cycles. Software picks a device by writing a configuration-address word in which one bit between 11 and 31 stands for the target device. On the write the block converts that bit into a numeric device field and forces the enable bit and bus number 1. The standard enable/bus/device/function/register word it keeps is driven to the downstream configuration unit.

Reads of the same register return the stored word converted back: the device number becomes a single set bit again, and the function and register bits are passed through. The block also works out the offset into the configuration data window. Byte and halfword accesses keep only the low three address bits. Word accesses pass the full address through.

Top module: `cfgx_addr_xlate`

## Requirements
- R1: On a write, the block finds the lowest set bit position i among write-data bits 11..31. The stored word then has bits 15:11 equal to i (values 11..31).
- R2: When write-data bits 31:11 are all zero, the stored device field (bits 15:11) is zero, and bit 16 is still set.
- R3: Stored bits 10:2 equal the written bits 10:2. Stored bits 1:0 and 30:17 are zero after every write.
- R4: Every accepted write leaves stored bit 31 (enable) and bit 16 (bus 1) set.
- R5: The read value equals (1 << stored[15:11]) OR (stored[10:8] << 8) OR (stored AND 0xFC).
- R6: Reset clears the stored word to zero, so the read value after reset is 0x00000001.
- R7: The stored word changes on the first clock edge at which write enable is high. With write enable low it holds, whatever the write data is.
- R8: The window size code selects the offset. Codes 2'b00 (byte) and 2'b01 (halfword) give the window offset as address AND 7. Codes 2'b10 and 2'b11 (word) give the full address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe for the address register |
| wr_data_i | input | 32 | CPU write data (one-hot device select form) |
| rd_data_o | output | 32 | CPU read view of the register (one-hot form) |
| win_addr_i | input | ADDR_W | Data-window access address |
| win_size_i | input | 2 | Data-window access size code |
| win_offset_o | output | ADDR_W | Offset into the configuration data register |
| cfg_addr_o | output | 32 | Translated configuration address to downstream unit |

## Verification
The assertions assume that write enable and write data are stable and known at each rising edge. They also assume reset is applied before the first write. The bench drives every input on the falling edge and holds reset for several cycles before any access. The one-hot read check relies only on the stored word, which is always a product of the encoder, so no input pattern can break it. The stimulus still covers the single-bit, two-bit and zero cases that make the encoder's search result reach each value, including the empty-search value.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int WORD_W     = 32;
    localparam int SEARCH_LO  = 11;
    localparam int ENABLE_BIT = 31;
    localparam int BUS1_BIT   = 16;
    localparam int DEV_LSB    = 11;
    localparam int FUNC_LSB   = 8;
    localparam logic [WORD_W-1:0] KEEP_MASK = 32'h0000_07FC;
    localparam logic [WORD_W-1:0] REG_MASK  = 32'h0000_00FC;
    localparam int IDX_W      = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORDX = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [WORD_W-1:0] cfg_addr;
    } xlate_state_t;

endpackage

// File: rtl/cfgx_encode.sv
module cfgx_encode
    import cfgx_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o
);
    logic [IDX_W-1:0] idx;

    // Lowest set bit in the search range; WORD_W when none is set.
    always_comb begin
        idx = IDX_W'(WORD_W);
        for (int k = WORD_W - 1; k >= SEARCH_LO; k--) begin
            if (data_i[k]) idx = IDX_W'(k);
        end
    end

    always_comb begin
        word_o = (WORD_W'(1) << ENABLE_BIT)
               | (WORD_W'(1) << BUS1_BIT)
               | (data_i & KEEP_MASK)
               | (WORD_W'(idx) << DEV_LSB);
    end
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
(
    input  logic [WORD_W-1:0] cfg_i,
    output logic [WORD_W-1:0] rd_o
);
    logic [7:0] devfn;

    always_comb begin
        devfn = cfg_i[FUNC_LSB +: 8];
        rd_o  = (WORD_W'(1) << devfn[7:3])
              | (WORD_W'(devfn[2:0]) << FUNC_LSB)
              | (cfg_i & REG_MASK);
    end
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic [ADDR_W-1:0] offset_o
);
    localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'(7);

    always_comb begin
        case (acc_size_e'(size_i))
            SZ_BYTE, SZ_HALF: offset_o = addr_i & LANE_MASK;
            default:          offset_o = addr_i;
        endcase
    end
endmodule

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate
    import cfgx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    input  logic [ADDR_W-1:0] win_addr_i,
    input  logic [1:0]        win_size_i,
    output logic [ADDR_W-1:0] win_offset_o,
    output logic [31:0]       cfg_addr_o
);
    xlate_state_t       st_d, st_q;
    logic [WORD_W-1:0]  enc_word;

    cfgx_encode u_enc (
        .data_i (wr_data_i),
        .word_o (enc_word)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) st_d.cfg_addr = enc_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_addr_o = st_q.cfg_addr;

    cfgx_decode u_dec (
        .cfg_i (st_q.cfg_addr),
        .rd_o  (rd_data_o)
    );

    cfgx_lane #(.ADDR_W(ADDR_W)) u_lane (
        .addr_i   (win_addr_i),
        .size_i   (win_size_i),
        .offset_o (win_offset_o)
    );

    AST_LOWEST_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && wr_data_i[SEARCH_LO] |=> cfg_addr_o[15:11] == 5'd11); // R1
    AST_EMPTY_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (wr_data_i[31:11] == '0) |=> (cfg_addr_o[15:11] == '0) && cfg_addr_o[16]); // R2
    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (cfg_addr_o[10:2] == $past(wr_data_i[10:2])) && (cfg_addr_o[1:0] == 2'b00)); // R3
    AST_ENABLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> cfg_addr_o[31] && cfg_addr_o[16]); // R4
    AST_READ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_data_o[31:11]) <= 1); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cfg_addr_o)); // R7
    AST_LANE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        !win_size_i[1] |-> (win_offset_o & ~ADDR_W'(7)) == '0); // R8
endmodule

// File: tb/tb_cfgx_addr_xlate.sv
module tb_cfgx_addr_xlate;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [31:0]       wr_data_i = '0;
    logic [31:0]       rd_data_o;
    logic [ADDR_W-1:0] win_addr_i = '0;
    logic [1:0]        win_size_i = '0;
    logic [ADDR_W-1:0] win_offset_o;
    logic [31:0]       cfg_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model = '0;

    always #2 clk = ~clk;

    cfgx_addr_xlate #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .win_addr_i(win_addr_i), .win_size_i(win_size_i),
        .win_offset_o(win_offset_o), .cfg_addr_o(cfg_addr_o)
    );

    function automatic logic [31:0] enc(input logic [31:0] v);
        int i = 32;
        for (int k = 11; k <= 31; k++) if (v[k] && i == 32) i = k;
        return 32'h8001_0000 | (v & 32'h7FC) | (32'(i) << 11);
    endfunction

    function automatic logic [31:0] dec(input logic [31:0] s);
        return (32'd1 << s[15:11]) | (32'(s[10:8]) << 8) | (s & 32'hFC);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Write, check no early update (R7), then check stored and read views.
    task automatic wr(input logic [31:0] v, input string req);
        @(negedge clk);
        wr_en_i = 1'b1;
        wr_data_i = v;
        #1 check("R7 pre-edge", cfg_addr_o, model);
        @(negedge clk);
        wr_en_i = 1'b0;
        model = enc(v);
        check(req, cfg_addr_o, model);
        check("R4", cfg_addr_o & 32'h8001_0000, 32'h8001_0000);
        check("R3", cfg_addr_o & 32'h7FFE_0003, 32'h0);
        check("R5", rd_data_o, dec(model));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] lfsr;
        repeat (4) @(negedge clk);
        check("R6 reset", cfg_addr_o, 32'h0);
        check("R6 read", rd_data_o, 32'h1);
        rst_n = 1'b1;

        // single-bit sweep: bits below 11 give the empty search (R2)
        for (int k = 0; k < 32; k++) wr(32'd1 << k, k < 11 ? "R2" : "R1");
        wr(32'h0, "R2");
        wr(32'h0000_07FF, "R2");

        // two-bit sweep: lower bit must win (R1)
        for (int a = 11; a < 32; a++)
            for (int b = a + 1; b < 32; b++)
                wr((32'd1 << a) | (32'd1 << b) | 32'h5A6, "R1");

        // pseudo-random patterns, low bits carried (R3)
        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 64; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wr(lfsr, "R3");
        end

        // hold with write enable low (R7)
        wr(32'h0010_0124, "R1");
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            wr_data_i = 32'hFFFF_F800 >> n;
            @(negedge clk);
            check("R7 hold", cfg_addr_o, model);
        end

        // data-window lane select (R8)
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 80; a++) begin
                logic [31:0] addr;
                addr = 32'(a) * 32'h0101_0013;
                @(negedge clk);
                win_addr_i = addr;
                win_size_i = 2'(s);
                #1 check("R8", win_offset_o, (s < 2) ? (addr & 32'h7) : addr);
            end
        end

        // reset after activity (R6)
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R6 re-reset", cfg_addr_o, 32'h0);
        check("R6 re-read", rd_data_o, 32'h1);
        model = '0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(32'h8000_0000, "R1");

        summary();
    end
endmodule